// File: doc/BRIEF.md
# Ethernet Receive Frame Gate

This block sits between the byte stream coming up from the PHY and the write port of the receive FIFO. Each incoming frame is marked by a start flag on its first byte and an end flag on its last byte. At the start of every frame the gate decides whether the frame is stored. It discards a frame that begins while the port is transmitting only in half duplex with the own-transmit-discard bit set. That frame is the PHY's echo of the port's own transmission. Every other frame is written.

The gate can also remove the trailing four-byte frame check sequence (FCS). When the keep-CRC bit is clear, a four-entry delay line holds back the newest bytes. Each byte is released only after four later bytes have arrived, so the FCS never reaches the FIFO. The final data byte carries a last flag. A one-clock receive interrupt accompanies that last write unless interrupts are masked. A receive-ready flag marks the span during which a stored frame is being written.

Full duplex is in force when either the software duplex bit or the hardware full-duplex pin is high. Setting the software duplex bit together with the discard bit selects loopback. In loopback the frame returned by the PHY is accepted, because the block has no internal loopback path.

Top module: `rx_frame_gate`

## Requirements
- R1: Full duplex is in effect when `cfg_fdx_sw` or `fdx_pin` is 1. Either source alone makes the port accept frames that start while transmitting.
- R2: A frame is discarded when, on its start byte, full duplex is off, `cfg_own_dis`=1 and `tx_busy`=1. A discarded frame produces no `wr_en`, no `rx_ready` and no `rx_irq`. The decision taken at the start byte holds for the whole frame, whatever `tx_busy` does afterwards.
- R3: In half duplex with `cfg_own_dis`=0, a frame that starts while `tx_busy`=1 is stored like any other frame.
- R4: In full duplex, a frame that starts while `tx_busy`=1 is stored as a normal reception.
- R5: With `cfg_fdx_sw`=1 and `cfg_own_dis`=1 (loopback), a frame that starts while `tx_busy`=1 is stored.
- R6: When `cfg_keep_fcs`=1 at the start byte, every byte of an accepted frame, FCS included, is written in the cycle after it arrives. The end byte is written with `wr_last`=1.
- R7: When `cfg_keep_fcs`=0 at the start byte, the last four bytes of the frame are never written. Data byte i is written in the cycle after byte i+4 arrives. The final data byte is written with `wr_last`=1 in the cycle after the end byte arrives. A frame of four bytes or fewer writes nothing.
- R8: `rx_irq` is a one-cycle pulse that occurs together with the `wr_last` write of an accepted frame.
- R9: When `cfg_irq_off`=1 in the cycle the end byte arrives, no `rx_irq` is produced, but the frame is still written in full.
- R10: `rx_ready` rises together with the first write of a frame. It stays high until the cycle after the `wr_last` write, or until a new start byte arrives with no write.
- R11: Valid bytes outside a frame are ignored. A start byte arriving inside a frame abandons that frame, with no `wr_last` and no `rx_irq`, and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_data | input | DW | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| tx_busy | input | 1 | Port is transmitting |
| cfg_fdx_sw | input | 1 | Software full-duplex bit |
| fdx_pin | input | 1 | Hardware full-duplex pin |
| cfg_own_dis | input | 1 | Discard own looped-back transmission |
| cfg_keep_fcs | input | 1 | Store the four FCS bytes |
| cfg_irq_off | input | 1 | Mask the receive interrupt |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | DW | FIFO write data |
| wr_last | output | 1 | Write is the final byte of the frame |
| rx_ready | output | 1 | A stored frame is being written |
| rx_irq | output | 1 | One-cycle receive interrupt |

## Verification
Timing differs by mode. With FCS kept, each byte's write is due one cycle after the byte is sampled. With FCS stripped, a byte's write is due one cycle after the byte four positions later is sampled, however many idle cycles lie between them. The `wr_last` write, the interrupt pulse and the rise of `rx_ready` all appear after the same clock edge as the write they belong to, and `rx_ready` falls one cycle after the last write. The bench's reference model steps on the rising edge using the same sampled inputs as the design, and every output is compared against it on the following falling edge. Because of this, each expectation is checked in exactly the cycle it is due, and idle gaps inside frames test the stripped-mode release rule.

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int DW      = 8,
  parameter int FCS_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          tx_busy,
  input  logic          cfg_fdx_sw,
  input  logic          fdx_pin,
  input  logic          cfg_own_dis,
  input  logic          cfg_keep_fcs,
  input  logic          cfg_irq_off,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          wr_last,
  output logic          rx_ready,
  output logic          rx_irq
);
  localparam int CW = $clog2(FCS_LEN + 1);

  logic [DW-1:0] dly [FCS_LEN];
  logic [CW-1:0] cnt;
  logic          in_q, acc_q, keep_q;

  wire fdx      = cfg_fdx_sw | fdx_pin;
  wire start    = rx_valid & rx_sof;
  wire drop_own = ~fdx & cfg_own_dis & tx_busy;
  wire acc_now  = start ? ~drop_own : acc_q;
  wire keep_now = start ? cfg_keep_fcs : keep_q;
  wire in_now   = start | in_q;
  wire take     = rx_valid & in_now & acc_now;
  wire [CW-1:0] cnt_now = start ? '0 : cnt;
  wire full     = (cnt_now == CW'(FCS_LEN));
  wire do_wr    = take & (keep_now | full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q     <= 1'b0;
      acc_q    <= 1'b0;
      keep_q   <= 1'b0;
      cnt      <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      wr_last  <= 1'b0;
      rx_ready <= 1'b0;
      rx_irq   <= 1'b0;
      for (int i = 0; i < FCS_LEN; i++) dly[i] <= '0;
    end else begin
      if (rx_valid) in_q <= in_now & ~rx_eof;
      if (start) begin
        acc_q  <= ~drop_own;
        keep_q <= cfg_keep_fcs;
      end
      if (rx_valid & rx_eof)
        cnt <= '0;
      else if (take & ~keep_now & ~full)
        cnt <= cnt_now + 1'b1;
      else
        cnt <= cnt_now;
      if (take & ~keep_now) begin
        dly[0] <= rx_data;
        for (int i = 1; i < FCS_LEN; i++) dly[i] <= dly[i-1];
      end
      wr_en   <= do_wr;
      wr_data <= keep_now ? rx_data : dly[FCS_LEN-1];
      wr_last <= do_wr & rx_eof;
      rx_irq  <= do_wr & rx_eof & ~cfg_irq_off;
      if (do_wr)
        rx_ready <= 1'b1;
      else if (wr_last | start)
        rx_ready <= 1'b0;
    end
  end

  p_irq_with_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (wr_en && wr_last));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !$past(cfg_irq_off));

  p_own_echo_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !cfg_fdx_sw && !fdx_pin && cfg_own_dis && tx_busy) |=> !wr_en);

  p_ready_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rx_ready);

  p_keep_next_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && cfg_keep_fcs && (cfg_fdx_sw || fdx_pin || !cfg_own_dis || !tx_busy))
    |=> (wr_en && wr_data == $past(rx_data)));

  p_strip_holds_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !cfg_keep_fcs) |=> !wr_en);
endmodule

// File: tb/rx_frame_gate_test.sv
module rx_frame_gate_test;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, tx_busy = 0;
  logic [7:0] rx_data = 0;
  logic cfg_fdx_sw = 0, fdx_pin = 0, cfg_own_dis = 0, cfg_keep_fcs = 1, cfg_irq_off = 0;
  logic wr_en, wr_last, rx_ready, rx_irq;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  int sc_bytes = 0, sc_irqs = 0;
  bit done = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  rx_frame_gate uut (.*);

  byte unsigned q[$];
  bit m_in = 0, m_acc = 0, m_keep = 0;
  bit e_wr = 0, e_last = 0, e_rdy = 0, e_irq = 0;
  logic [7:0] e_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_in = 0; m_acc = 0; m_keep = 0;
      e_wr = 0; e_last = 0; e_rdy = 0; e_irq = 0;
    end else begin
      bit w, l;
      logic [7:0] d;
      w = 0; l = 0; d = 0;
      if (rx_valid) begin
        if (rx_sof) begin
          m_in = 1;
          m_acc = !(!(cfg_fdx_sw || fdx_pin) && cfg_own_dis && tx_busy);
          m_keep = cfg_keep_fcs;
          q.delete();
        end
        if (m_in && m_acc) begin
          q.push_back(rx_data);
          if (m_keep || q.size() == 5) begin
            w = 1; d = q.pop_front(); l = rx_eof;
          end
        end
        if (rx_eof) begin m_in = 0; q.delete(); end
      end
      if (w) e_rdy = 1;
      else if (e_last || (rx_valid && rx_sof)) e_rdy = 0;
      e_irq = w && l && !cfg_irq_off;
      e_wr = w; e_last = l;
      if (w) e_data = d;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("wr_en", wr_en, e_wr);
    if (e_wr) begin
      chk("wr_data", wr_data, e_data);
      chk("wr_last", wr_last, e_last);
    end
    chk("rx_ready", rx_ready, e_rdy);
    chk("rx_irq", rx_irq, e_irq);
    if (wr_en) sc_bytes++;
    if (rx_irq) sc_irqs++;
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0;
    end
  endtask

  task automatic send(int len, int gap, int seed, bit close, int busy_mid);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + i * 7);
      rx_sof = (i == 0); rx_eof = close && (i == len - 1);
      if (i == 1 && busy_mid >= 0) tx_busy = busy_mid[0];
      if (gap > 0 && (i % 2) == 1) idle(gap);
    end
    idle(1);
  endtask

  task automatic scene(string t, int exp_b, int exp_i);
    idle(3);
    tag = t;
    chk("frame bytes", sc_bytes, exp_b);
    chk("frame irqs", sc_irqs, exp_i);
    sc_bytes = 0; sc_irqs = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "reset";
    chk("wr_en", wr_en, 0); chk("rx_ready", rx_ready, 0); chk("rx_irq", rx_irq, 0);
    rst_n = 1;
    idle(2);
    tag = "R6";  send(8, 0, 8'h10, 1, -1); scene("R6", 8, 1);
    send(1, 0, 8'h33, 1, -1); scene("R6", 1, 1);
    cfg_keep_fcs = 0;
    tag = "R7";  send(10, 1, 8'h40, 1, -1); scene("R7", 6, 1);
    send(4, 0, 8'h50, 1, -1); scene("R7", 0, 0);
    send(5, 2, 8'h60, 1, -1); scene("R7", 1, 1);
    cfg_keep_fcs = 1; cfg_own_dis = 1; tx_busy = 1;
    tag = "R2";  send(8, 0, 8'h70, 1, -1); scene("R2", 0, 0);
    send(8, 1, 8'h71, 1, 0); scene("R2", 0, 0);
    tx_busy = 0;
    send(8, 0, 8'h72, 1, 1); scene("R2", 8, 1);
    cfg_own_dis = 0; tx_busy = 1;
    tag = "R3";  send(8, 0, 8'h80, 1, -1); scene("R3", 8, 1);
    cfg_own_dis = 1; fdx_pin = 1;
    tag = "R1";  send(8, 0, 8'h90, 1, -1); scene("R1", 8, 1);
    fdx_pin = 0; cfg_fdx_sw = 1; cfg_own_dis = 0; cfg_keep_fcs = 0;
    tag = "R4";  send(9, 1, 8'hA0, 1, -1); scene("R4", 5, 1);
    cfg_own_dis = 1; cfg_keep_fcs = 1;
    tag = "R5";  send(8, 0, 8'hB0, 1, -1); scene("R5", 8, 1);
    cfg_fdx_sw = 0; cfg_own_dis = 0; tx_busy = 0; cfg_irq_off = 1;
    tag = "R9";  send(8, 0, 8'hC0, 1, -1); scene("R9", 8, 0);
    cfg_irq_off = 0;
    tag = "R11";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_eof = 0; rx_data = 8'(i);
    end
    scene("R11", 0, 0);
    send(3, 0, 8'hD0, 0, -1); send(6, 0, 8'hD8, 1, -1); scene("R11", 9, 1);
    cfg_keep_fcs = 0;
    send(6, 0, 8'hE0, 0, -1); send(7, 0, 8'hE8, 1, -1); scene("R11", 5, 1);
    tag = "R8";  send(12, 1, 8'hF0, 1, -1); scene("R8", 8, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule